// File: doc/BRIEF.md
# Per-Core Power Sequencer for a Four-Core Cluster

This block sits next to a cluster of processor cores. It drives each core's power enable and reset. Software sees it as a small register space on a word-wide bus.

To bring a core up, software sets that core's bit in a wake register and polls until the bit drops back to zero. To take a core down, software first writes a standby code into that core's own control register. The power-down starts only when the core later raises its wait-for-interrupt signal. A packed status word gives the power phase of every core at once.

Power-up and power-down each run for a fixed, parameterised number of cycles, which stands in for a power-good delay. The core's reset stays asserted until power-up is complete.

Top module: `pcpm_top`

## Requirements
- R1: After reset, core 0 is running and cores 1 to 3 are off, so `core_pwr_en` is 4'b0001 and `core_rst` is 4'b1110. The wake register, every control register and the unused status bits read zero, and the status word reads 0x3330.
- R2: Writing to byte offset 0x10 with data bit n set makes an off core n begin power-up. Bit n of a read at 0x10 stays 1 while that request is pending and returns to 0 once the core is running.
- R3: Power-up lasts UP_CYCLES clock cycles. During power-up the status field reads 1, the core's power enable is 1 and its reset is 1. After power-up the field reads 0 and the reset is 0.
- R4: A wake bit aimed at a core that is already running has no effect, and the bit reads back as 0.
- R5: The status word at byte offset 0x40 holds core n in bits [4n+3:4n]. The low two bits of each field encode the phase: 0 running, 1 powering up, 2 powering down, 3 off. The upper two bits of each field read 0.
- R6: The control register of core n sits at byte offset 0x100 + 0x10*n. It stores and returns the low two bits of the written data. Writing 3 arms standby but changes nothing until the core next signals wait-for-interrupt.
- R7: A running core whose control register holds 3 and whose wait-for-interrupt input is high enters power-down on the next edge. The status field reads 2 and reset is asserted for DN_CYCLES cycles. After that the field reads 3, the power enable is 0 and the control register reads 0.
- R8: Wait-for-interrupt has no effect on a core whose control register holds any value other than 3.
- R9: A wake request written while the core is powering down is kept pending and reads as 1. When the core reaches off, power-up begins on the following edge.
- R10: Reads from any offset other than the wake, status and control registers return 0. Writes to those offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| core_wfi | input | 4 | Wait-for-interrupt indication, one bit per core |
| core_pwr_en | output | 4 | Power enable, one bit per core |
| core_rst | output | 4 | Core reset, active high, one bit per core |

## Verification
A corrupted phase register in one core shows within the same cycle in three places: that core's power enable, its reset, and its nibble of the status word. A phase counter that is off by one moves the edge where status changes from 1 to 0 or from 2 to 3 by one cycle. A comparison made on every clock catches that at once. A wake request flag that is lost or stuck shows at 0x10 on the next read: either the bit never clears, or a core that went down with a request pending stays off.

// File: rtl/pcpm_pkg.sv
// Shared definitions for the per-core power sequencer.
// Assumes the phase encoding is also the software-visible status code.
package pcpm_pkg;
    typedef enum logic [1:0] {
        PS_RUN  = 2'd0,
        PS_UP   = 2'd1,
        PS_DOWN = 2'd2,
        PS_OFF  = 2'd3
    } pstate_e;

    localparam logic [1:0] ARM_STANDBY = 2'd3;
endpackage

// File: rtl/pcpm_core_seq.sv
// One core's power sequencer. It holds the phase, the pending wake flag,
// the standby control field and the phase timer.
// Assumes UP_CYCLES and DN_CYCLES are at least 1.
module pcpm_core_seq
    import pcpm_pkg::*;
#(
    parameter int UP_CYCLES = 8,
    parameter int DN_CYCLES = 6,
    parameter bit START_ON  = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_set,
    input  logic       ctrl_we,
    input  logic [1:0] ctrl_wd,
    input  logic       wfi,
    output pstate_e    state,
    output logic       req,
    output logic [1:0] ctrl,
    output logic       pwr_en,
    output logic       core_rst
);
    localparam int MAXC = (UP_CYCLES > DN_CYCLES) ? UP_CYCLES : DN_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    // Phase transitions, request tracking and control-field upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= START_ON ? PS_RUN : PS_OFF;
            cnt   <= '0;
            req   <= 1'b0;
            ctrl  <= 2'd0;
        end else begin
            if (ctrl_we) ctrl <= ctrl_wd;
            if (wake_set && state != PS_RUN) req <= 1'b1;
            unique case (state)
                PS_RUN: begin
                    if (wfi && ctrl == ARM_STANDBY) begin
                        state <= PS_DOWN;
                        cnt   <= CW'(DN_CYCLES - 1);
                    end
                end
                PS_UP: begin
                    if (cnt == '0) begin
                        state <= PS_RUN;
                        req   <= 1'b0;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                PS_DOWN: begin
                    if (cnt == '0) begin
                        state <= PS_OFF;
                        ctrl  <= 2'd0;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                PS_OFF: begin
                    if (req || wake_set) begin
                        state <= PS_UP;
                        cnt   <= CW'(UP_CYCLES - 1);
                    end
                end
                default: state <= PS_OFF;
            endcase
        end
    end

    // Outputs to the core follow the phase.
    always_comb begin
        pwr_en   = (state != PS_OFF);
        core_rst = (state != PS_RUN);
    end

    a_r7_down_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_DOWN && $past(state) == PS_RUN) |-> ($past(wfi) && $past(ctrl) == ARM_STANDBY));
    a_r3_up_ends_running: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PS_UP && state != PS_UP) |-> (state == PS_RUN));
    a_r7_ctrl_cleared_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PS_DOWN && state == PS_OFF) |-> (ctrl == 2'd0));
    a_r4_no_req_running: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_RUN) |-> !req);
    a_r9_pending_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_OFF && req) |=> (state == PS_UP));
endmodule

// File: rtl/pcpm_bus_dec.sv
// Register decode for the sequencer. It turns bus writes into per-core
// strobes and muxes read data.
// Assumes exact byte addresses; any other address reads zero.
module pcpm_bus_dec #(
    parameter int NCORES      = 4,
    parameter int AW          = 12,
    parameter int DW          = 32,
    parameter int WAKE_OFS    = 'h10,
    parameter int STAT_OFS    = 'h40,
    parameter int CTRL_BASE   = 'h100,
    parameter int CTRL_STRIDE = 'h10
) (
    input  logic [AW-1:0]       addr,
    input  logic                we,
    input  logic [DW-1:0]       wdata,
    input  logic [NCORES-1:0]   req_vec,
    input  logic [2*NCORES-1:0] state_vec,
    input  logic [2*NCORES-1:0] ctrl_vec,
    output logic [NCORES-1:0]   wake_set,
    output logic [NCORES-1:0]   ctrl_we,
    output logic [1:0]          ctrl_wd,
    output logic [DW-1:0]       rdata
);
    logic [NCORES-1:0] ctrl_hit;
    logic              unused_hi;

    assign unused_hi = ^wdata;
    assign ctrl_wd   = wdata[1:0];

    // Per-core address match and write strobes.
    for (genvar i = 0; i < NCORES; i++) begin : g_core
        assign ctrl_hit[i] = (addr == AW'(CTRL_BASE + CTRL_STRIDE * i));
        assign ctrl_we[i]  = we && ctrl_hit[i];
        assign wake_set[i] = we && (addr == AW'(WAKE_OFS)) && wdata[i];
    end

    // Read multiplexer: wake, packed status, control, else zero.
    always_comb begin
        rdata = '0;
        if (addr == AW'(WAKE_OFS)) begin
            rdata[NCORES-1:0] = req_vec;
        end else if (addr == AW'(STAT_OFS)) begin
            for (int i = 0; i < NCORES; i++)
                rdata[4*i +: 4] = {2'b00, state_vec[2*i +: 2]};
        end else begin
            for (int i = 0; i < NCORES; i++)
                if (ctrl_hit[i]) rdata[1:0] = ctrl_vec[2*i +: 2];
        end
    end
endmodule

// File: rtl/pcpm_top.sv
// Per-core power sequencer for a four-core cluster. It holds one sequencer
// per core behind a small register decoder.
// Assumes NCORES*4 <= DW so that the packed status fits one word.
module pcpm_top
    import pcpm_pkg::*;
#(
    parameter int NCORES    = 4,
    parameter int AW        = 12,
    parameter int DW        = 32,
    parameter int UP_CYCLES = 8,
    parameter int DN_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NCORES-1:0] core_wfi,
    output logic [NCORES-1:0] core_pwr_en,
    output logic [NCORES-1:0] core_rst
);
    logic [NCORES-1:0]   wake_set, ctrl_we, req_vec;
    logic [1:0]          ctrl_wd;
    logic [2*NCORES-1:0] state_vec, ctrl_vec;

    pcpm_bus_dec #(.NCORES(NCORES), .AW(AW), .DW(DW)) u_dec (
        .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .req_vec(req_vec), .state_vec(state_vec), .ctrl_vec(ctrl_vec),
        .wake_set(wake_set), .ctrl_we(ctrl_we), .ctrl_wd(ctrl_wd),
        .rdata(bus_rdata)
    );

    // One sequencer per core; core 0 comes out of reset running.
    for (genvar i = 0; i < NCORES; i++) begin : g_seq
        pstate_e st;
        pcpm_core_seq #(
            .UP_CYCLES(UP_CYCLES), .DN_CYCLES(DN_CYCLES), .START_ON(i == 0)
        ) u_seq (
            .clk(clk), .rst_n(rst_n),
            .wake_set(wake_set[i]), .ctrl_we(ctrl_we[i]), .ctrl_wd(ctrl_wd),
            .wfi(core_wfi[i]),
            .state(st), .req(req_vec[i]), .ctrl(ctrl_vec[2*i +: 2]),
            .pwr_en(core_pwr_en[i]), .core_rst(core_rst[i])
        );
        assign state_vec[2*i +: 2] = st;
    end
endmodule

// File: tb/pcpm_top_bench.sv
module pcpm_top_bench;
    localparam int UP = 8;
    localparam int DN = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  core_wfi = '0;
    logic [3:0]  core_pwr_en, core_rst;

    int checks = 0, failures = 0;
    bit mon_en = 0, done = 0;
    int mst[4], mcnt[4], mreq[4], mctrl[4];

    always #5 clk = ~clk;

    pcpm_top #(.UP_CYCLES(UP), .DN_CYCLES(DN)) u_pcpm_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_wfi(core_wfi),
        .core_pwr_en(core_pwr_en), .core_rst(core_rst)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < 4; n++) begin
                mst[n] = (n == 0) ? 0 : 3; mcnt[n] = 0; mreq[n] = 0; mctrl[n] = 0;
            end
        end else begin
            for (int n = 0; n < 4; n++) begin
                bit ws, cw;
                int ns, nc, nr, nk;
                ws = bus_we && bus_addr == 12'h010 && bus_wdata[n];
                cw = bus_we && bus_addr == 12'(256 + 16 * n);
                ns = mst[n]; nc = mcnt[n]; nr = mreq[n];
                nk = cw ? int'(bus_wdata[1:0]) : mctrl[n];
                if (ws && mst[n] != 0) nr = 1;
                if (mst[n] == 0) begin
                    if (core_wfi[n] && mctrl[n] == 3) begin ns = 2; nc = DN - 1; end
                end else if (mst[n] == 1) begin
                    if (mcnt[n] == 0) begin ns = 0; nr = 0; end else nc = mcnt[n] - 1;
                end else if (mst[n] == 2) begin
                    if (mcnt[n] == 0) begin ns = 3; nk = 0; end else nc = mcnt[n] - 1;
                end else begin
                    if (mreq[n] != 0 || ws) begin ns = 1; nc = UP - 1; end
                end
                mst[n] = ns; mcnt[n] = nc; mreq[n] = nr; mctrl[n] = nk;
            end
        end
    end

    function automatic logic [31:0] model_rd(input logic [11:0] a);
        logic [31:0] v = '0;
        for (int n = 0; n < 4; n++) begin
            if (a == 12'h010) v[n] = (mreq[n] != 0);
            if (a == 12'h040) v[4*n +: 4] = 4'(mst[n]);
            if (a == 12'(256 + 16 * n)) v = 32'(mctrl[n]);
        end
        return v;
    endfunction

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        #1;
        if (mon_en) begin
            logic [3:0] ep, er;
            logic [31:0] ed;
            string tg;
            for (int n = 0; n < 4; n++) begin
                ep[n] = (mst[n] != 3);
                er[n] = (mst[n] != 0);
            end
            chk(core_pwr_en === ep, "R7 pwr_en", 32'(core_pwr_en), 32'(ep));
            chk(core_rst === er, "R3 core_rst", 32'(core_rst), 32'(er));
            ed = model_rd(bus_addr);
            if (bus_addr == 12'h010) tg = "R2 wake read";
            else if (bus_addr == 12'h040) tg = "R5 status read";
            else if (bus_addr >= 12'h100 && bus_addr <= 12'h130 && bus_addr[3:0] == 0) tg = "R6 ctrl read";
            else tg = "R10 unmapped read";
            chk(bus_rdata === ed, tg, bus_rdata, ed);
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); bus_addr = a;
        #2;
        chk(bus_rdata === exp, tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1;
        // R1: reset state
        rd(12'h040, 32'h3330, "R1 status after reset");
        rd(12'h010, 32'h0, "R1 wake after reset");
        rd(12'h100, 32'h0, "R1 ctrl0 after reset");
        #1;
        chk(core_pwr_en === 4'b0001, "R1 pwr_en", 32'(core_pwr_en), 32'h1);
        chk(core_rst === 4'b1110, "R1 core_rst", 32'(core_rst), 32'he);
        // R2, R3: wake core 1
        wr(12'h010, 32'h2);
        rd(12'h010, 32'h2, "R2 pending bit");
        rd(12'h040, 32'h3310, "R3 powering up");
        idle(10);
        rd(12'h010, 32'h0, "R2 cleared");
        rd(12'h040, 32'h3300, "R3 running");
        #1;
        chk(core_rst === 4'b1100, "R3 reset released", 32'(core_rst), 32'hc);
        // R4: wake to running core
        wr(12'h010, 32'h1);
        rd(12'h010, 32'h0, "R4 wake to running");
        rd(12'h040, 32'h3300, "R4 status unchanged");
        // R8: wfi without arm
        @(negedge clk); core_wfi = 4'b0010;
        idle(3);
        rd(12'h040, 32'h3300, "R8 wfi unarmed");
        wr(12'h110, 32'h2);
        rd(12'h110, 32'h2, "R6 ctrl stores value");
        rd(12'h040, 32'h3300, "R8 wfi with ctrl 2");
        @(negedge clk); core_wfi = 4'b0000;
        // R6, R7: arm then wfi
        wr(12'h110, 32'h3);
        rd(12'h110, 32'h3, "R6 armed");
        idle(3);
        rd(12'h040, 32'h3300, "R6 armed waits for wfi");
        @(negedge clk); core_wfi = 4'b0010;
        rd(12'h040, 32'h3320, "R7 powering down");
        @(negedge clk); core_wfi = 4'b0000;
        idle(8);
        rd(12'h040, 32'h3330, "R7 off");
        rd(12'h110, 32'h0, "R7 ctrl cleared");
        #1;
        chk(core_pwr_en === 4'b0001, "R7 pwr_en off", 32'(core_pwr_en), 32'h1);
        // R5, R9: wake two cores, then wake during power-down
        wr(12'h010, 32'hc);
        idle(10);
        rd(12'h040, 32'h0030, "R5 packed status");
        wr(12'h120, 32'h3);
        @(negedge clk); core_wfi = 4'b0100;
        @(negedge clk); core_wfi = 4'b0000;
        wr(12'h010, 32'h4);
        rd(12'h010, 32'h4, "R9 pending during down");
        rd(12'h040, 32'h0230, "R9 still powering down");
        idle(14);
        rd(12'h040, 32'h0030, "R9 back up");
        rd(12'h010, 32'h0, "R9 request done");
        // R10: unmapped offsets
        wr(12'h020, 32'hffff_ffff);
        wr(12'h104, 32'h3);
        wr(12'h044, 32'h3);
        rd(12'h020, 32'h0, "R10 read 0x20");
        rd(12'h104, 32'h0, "R10 read 0x104");
        rd(12'h044, 32'h0, "R10 read 0x44");
        rd(12'h040, 32'h0030, "R10 status untouched");
        rd(12'h100, 32'h0, "R10 ctrl0 untouched");
        idle(2);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule